// File: doc/BRIEF.md
# Supply Window Supervisor Reset Sequencer

This block is the digital decision core behind four supply window monitors. External comparators report, for each channel, one flag for "below the lower limit" and one flag for "above the upper limit". The block turns these flags into eight active-low per-channel fault outputs and one active-low system reset. The system reset is held low for a programmable number of clock cycles after the last fault source has gone away.

Three control inputs change how the outputs behave. An active-low manual-reset request passes through a glitch filter and then acts as one more reset source. An active-low margin-test enable forces every output high while the block keeps tracking its inputs. A supply-lockout flag forces every output low and has priority over margin mode. Every input is asynchronous. Each one passes through a two-flop synchronizer, and every output comes from a register.

Top module: `supply_window_seq`

## Requirements
- R1: With lockout inactive and margin enable high, `uv_out_n[i]` equals the inverse of `uv_flag[i]` and `ov_out_n[i]` equals the inverse of `ov_flag[i]`. Each output follows its own flag three clock edges after the flag changes: two synchronizer stages plus one output register.
- R2: With lockout inactive and margin enable high, `sys_rst_n` is low no later than four clock edges after any `uv_flag` or `ov_flag` bit goes high, and it stays low while that bit stays high.
- R3: After every fault source has cleared, `sys_rst_n` stays low for at least `TIMEOUT_CYC` clock cycles of continuous all-clear before it goes high. The fault sources are all flags, the filtered manual reset and lockout.
- R4: If any fault source becomes active while the timeout is running, the count is discarded. A full `TIMEOUT_CYC` period starts again once all sources are clear.
- R5: While `mr_n` is held low, `sys_rst_n` stays low. The timeout begins only after `mr_n` returns high.
- R6: A low pulse on `mr_n` that lasts fewer than `GLITCH_CYC` synchronized cycles has no effect on `sys_rst_n`. A low pulse of at least `GLITCH_CYC` cycles asserts it.
- R7: While `margin_n` is low and lockout is inactive, all eight fault outputs and `sys_rst_n` are driven high, whatever the flags and `mr_n` are doing.
- R8: Margin mode does not stop monitoring. Flags and the timeout keep being processed, so within three edges of `margin_n` rising every output shows the current monitored state.
- R9: While `lockout` is high, `sys_rst_n` and all eight fault outputs are driven low, even when `margin_n` is low. Lockout also counts as a fault source for the timeout.
- R10: While `rst_n` is low, all nine outputs are low. After `rst_n` is released, `sys_rst_n` stays low for a full timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag | input | NCH | Per-channel undervoltage comparator flag, 1 = below lower limit |
| ov_flag | input | NCH | Per-channel overvoltage comparator flag, 1 = above upper limit |
| mr_n | input | 1 | Manual-reset request, active low, glitch filtered |
| margin_n | input | 1 | Margin-test enable, active low, forces outputs high |
| lockout | input | 1 | Supply-lockout flag, active high, forces outputs low |
| uv_out_n | output | NCH | Per-channel undervoltage fault, active low |
| ov_out_n | output | NCH | Per-channel overvoltage fault, active low |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 20 and `GLITCH_CYC` = 4, with four channels and two synchronizer stages. A short timeout lets a full expiry, a restarted count and a timeout that finishes under margin mode all happen within a few dozen cycles. A glitch length of four cycles lets a two-cycle pulse on `mr_n` be shown as rejected and a ten-cycle pulse as accepted. The default values, sized for a 100 MHz clock, are used only when the design is elaborated on its own.

// File: rtl/swseq_pkg.sv
package swseq_pkg;

  // How the output register bank is driven in a given cycle.
  typedef enum logic [1:0] {
    DRV_LOCK = 2'd0,   // force everything low
    DRV_MASK = 2'd1,   // margin test: force everything high
    DRV_LIVE = 2'd2    // reflect monitored state
  } drive_mode_e;

  function automatic drive_mode_e pick_mode(input logic lock_act, input logic margin_n_s);
    if (lock_act)        return DRV_LOCK;
    else if (!margin_n_s) return DRV_MASK;
    else                 return DRV_LIVE;
  endfunction

endpackage

// File: rtl/swseq_sync.sv
module swseq_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= RST_VAL;
        else        stg[gi] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= RST_VAL;
        else        stg[gi] <= stg[gi-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/swseq_mr_filter.sv
module swseq_mr_filter #(
  parameter int GLITCH_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s,     // synchronized request, active low
  output logic mr_act      // filtered request, active high
);

  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

  logic [CW-1:0] low_run;

  // Asserts only after GLITCH_CYC consecutive low samples; releases at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      mr_act  <= 1'b0;
    end else if (mr_n_s) begin
      low_run <= '0;
      mr_act  <= 1'b0;
    end else if (!mr_act) begin
      if (low_run == LAST) mr_act <= 1'b1;
      else                 low_run <= low_run + 1'b1;
    end
  end

endmodule

// File: rtl/swseq_timer.sv
module swseq_timer #(
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_any,    // any fault source active this cycle
  output logic hold        // reset must stay asserted
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] clear_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clear_run <= '0;
      hold      <= 1'b1;
    end else if (src_any) begin
      clear_run <= '0;
      hold      <= 1'b1;
    end else if (hold) begin
      if (clear_run == LAST) hold <= 1'b0;
      else                   clear_run <= clear_run + 1'b1;
    end
  end

endmodule

// File: rtl/supply_window_seq.sv
module supply_window_seq
  import swseq_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 30,
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] uv_flag,
  input  logic [NCH-1:0] ov_flag,
  input  logic           mr_n,
  input  logic           margin_n,
  input  logic           lockout,
  output logic [NCH-1:0] uv_out_n,
  output logic [NCH-1:0] ov_out_n,
  output logic           sys_rst_n
);

  localparam int SW = 2*NCH + 3;
  // lockout, margin_n and mr_n idle in their safe/inactive level during reset
  localparam logic [SW-1:0] SYNC_IDLE = {3'b111, {(2*NCH){1'b0}}};

  logic [SW-1:0]  sync_q;
  logic [NCH-1:0] uv_s, ov_s;
  logic           mr_n_s, margin_n_s, lock_s;
  logic           mr_act, src_any, hold;
  drive_mode_e    mode;

  swseq_sync #(
    .WIDTH   (SW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({lockout, margin_n, mr_n, ov_flag, uv_flag}),
    .q     (sync_q)
  );

  assign uv_s       = sync_q[NCH-1:0];
  assign ov_s       = sync_q[2*NCH-1:NCH];
  assign mr_n_s     = sync_q[2*NCH];
  assign margin_n_s = sync_q[2*NCH+1];
  assign lock_s     = sync_q[2*NCH+2];

  swseq_mr_filter #(
    .GLITCH_CYC (GLITCH_CYC)
  ) u_mr (
    .clk    (clk),
    .rst_n  (rst_n),
    .mr_n_s (mr_n_s),
    .mr_act (mr_act)
  );

  assign src_any = (|uv_s) | (|ov_s) | mr_act | lock_s;

  swseq_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_any (src_any),
    .hold    (hold)
  );

  always_comb mode = pick_mode(lock_s, margin_n_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_out_n  <= '0;
      ov_out_n  <= '0;
      sys_rst_n <= 1'b0;
    end else begin
      unique case (mode)
        DRV_LOCK: begin
          uv_out_n  <= '0;
          ov_out_n  <= '0;
          sys_rst_n <= 1'b0;
        end
        DRV_MASK: begin
          uv_out_n  <= '1;
          ov_out_n  <= '1;
          sys_rst_n <= 1'b1;
        end
        default: begin
          uv_out_n  <= ~uv_s;
          ov_out_n  <= ~ov_s;
          sys_rst_n <= ~hold;
        end
      endcase
    end
  end

endmodule

// File: rtl/swseq_chk.sv
module swseq_chk #(
  parameter int NCH         = 4,
  parameter int GLITCH_CYC  = 30,
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] uv_s,
  input logic [NCH-1:0] ov_s,
  input logic           mr_n_s,
  input logic           margin_n_s,
  input logic           lock_s,
  input logic           mr_act,
  input logic           hold,
  input logic [NCH-1:0] uv_out_n,
  input logic [NCH-1:0] ov_out_n,
  input logic           sys_rst_n
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int GW = $clog2(GLITCH_CYC + 1);

  logic [TW-1:0] seen_clear;
  logic [GW-1:0] seen_low;
  logic          any_src;

  assign any_src = (|uv_s) | (|ov_s) | mr_act | lock_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_clear <= '0;
      seen_low   <= '0;
    end else begin
      if (any_src) seen_clear <= '0;
      else if (seen_clear != TW'(TIMEOUT_CYC)) seen_clear <= seen_clear + 1'b1;
      if (mr_n_s) seen_low <= '0;
      else if (seen_low != GW'(GLITCH_CYC)) seen_low <= seen_low + 1'b1;
    end
  end

  // R1
  uv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_s && margin_n_s) |=> (uv_out_n == ~$past(uv_s)));

  // R1
  ov_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_s && margin_n_s) |=> (ov_out_n == ~$past(ov_s)));

  // R2
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|uv_s) || (|ov_s) || mr_act) |=> hold);

  // R2
  rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_s && margin_n_s) |=> (sys_rst_n == !$past(hold)));

  // R3 R4
  timeout_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (seen_clear >= TW'(TIMEOUT_CYC)));

  // R6
  glitch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_act) |-> (seen_low >= GW'(GLITCH_CYC)));

  // R7
  margin_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_s && !margin_n_s) |=> ((&uv_out_n) && (&ov_out_n) && sys_rst_n));

  // R9
  lockout_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_s |=> ((uv_out_n == '0) && (ov_out_n == '0) && !sys_rst_n));

endmodule

bind supply_window_seq swseq_chk #(
  .NCH         (NCH),
  .GLITCH_CYC  (GLITCH_CYC),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .uv_s       (uv_s),
  .ov_s       (ov_s),
  .mr_n_s     (mr_n_s),
  .margin_n_s (margin_n_s),
  .lock_s     (lock_s),
  .mr_act     (mr_act),
  .hold       (hold),
  .uv_out_n   (uv_out_n),
  .ov_out_n   (ov_out_n),
  .sys_rst_n  (sys_rst_n)
);

// File: tb/tb_supply_window_seq.sv
`timescale 1ns/1ps
module tb_supply_window_seq;

  localparam int N  = 4;
  localparam int TO = 20;
  localparam int GL = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] uv_flag = '0;
  logic [N-1:0] ov_flag = '0;
  logic         mr_n = 1'b1;
  logic         margin_n = 1'b1;
  logic         lockout = 1'b0;
  logic [N-1:0] uv_out_n, ov_out_n;
  logic         sys_rst_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  supply_window_seq #(
    .NCH (N), .SYNC_STAGES (2), .GLITCH_CYC (GL), .TIMEOUT_CYC (TO)
  ) dut (
    .clk (clk), .rst_n (rst_n), .uv_flag (uv_flag), .ov_flag (ov_flag),
    .mr_n (mr_n), .margin_n (margin_n), .lockout (lockout),
    .uv_out_n (uv_out_n), .ov_out_n (ov_out_n), .sys_rst_n (sys_rst_n)
  );

  // Expected per-channel output from the requirements (R1, R7, R9)
  function automatic logic [N-1:0] exp_chan(input logic [N-1:0] f, input logic mg_n, input logic lk);
    if (lk)        return '0;
    else if (!mg_n) return '1;
    else           return ~f;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle_clear();
    uv_flag = '0; ov_flag = '0; mr_n = 1'b1; margin_n = 1'b1; lockout = 1'b0;
    step(TO + 10);
  endtask

  initial begin
    int low_seen;
    void'($urandom(32'd4242));
    step(3);
    // R10: reset state
    chk("R10 outputs in reset", {23'd0, uv_out_n, ov_out_n, sys_rst_n}, 32'd0);
    rst_n = 1'b1;
    step(TO);
    chk("R10 timeout after reset", {31'd0, sys_rst_n}, 32'd0);
    step(10);
    chk("R10 released after timeout", {31'd0, sys_rst_n}, 32'd1);
    chk("R1 idle channels high", {24'd0, uv_out_n, ov_out_n}, 32'hFF);

    // R1/R2 directed
    uv_flag = 4'b0010; step(5);
    chk("R1 uv channel", {28'd0, uv_out_n}, 32'hD);
    chk("R2 reset on uv", {31'd0, sys_rst_n}, 32'd0);
    uv_flag = '0; ov_flag = 4'b1000; step(5);
    chk("R1 ov channel", {28'd0, ov_out_n}, 32'h7);
    chk("R1 uv cleared", {28'd0, uv_out_n}, 32'hF);

    // R3: timeout length
    ov_flag = '0; step(TO);
    chk("R3 still low at timeout", {31'd0, sys_rst_n}, 32'd0);
    step(6);
    chk("R3 high after timeout", {31'd0, sys_rst_n}, 32'd1);

    // R4: restart
    uv_flag = 4'b0001; step(5); uv_flag = '0;
    step(12);
    ov_flag = 4'b0100; step(3); ov_flag = '0;
    step(TO);
    chk("R4 restarted count low", {31'd0, sys_rst_n}, 32'd0);
    step(8);
    chk("R4 high after restart", {31'd0, sys_rst_n}, 32'd1);

    // R5: manual reset held
    mr_n = 1'b0; step(3*TO);
    chk("R5 low while mr held", {31'd0, sys_rst_n}, 32'd0);
    mr_n = 1'b1; step(TO);
    chk("R5 low after mr release", {31'd0, sys_rst_n}, 32'd0);
    step(8);
    chk("R5 high after timeout", {31'd0, sys_rst_n}, 32'd1);

    // R6: glitch rejected, long pulse accepted
    mr_n = 1'b0; step(2); mr_n = 1'b1;
    low_seen = 0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (!sys_rst_n) low_seen++;
    end
    chk("R6 short pulse ignored", low_seen, 32'd0);
    mr_n = 1'b0; step(10);
    chk("R6 long pulse accepted", {31'd0, sys_rst_n}, 32'd0);
    mr_n = 1'b1;
    step(TO + 10);

    // R7: margin masks
    margin_n = 1'b0; uv_flag = 4'b1111; ov_flag = 4'b0101; mr_n = 1'b0; step(12);
    chk("R7 channels masked", {24'd0, uv_out_n, ov_out_n}, 32'hFF);
    chk("R7 reset masked", {31'd0, sys_rst_n}, 32'd1);
    // R8: monitoring continues
    uv_flag = '0; ov_flag = 4'b0100; mr_n = 1'b1; step(5);
    margin_n = 1'b1; step(4);
    chk("R8 ov state after margin", {28'd0, ov_out_n}, 32'hB);
    chk("R8 reset state after margin", {31'd0, sys_rst_n}, 32'd0);
    margin_n = 1'b0; step(2); ov_flag = '0; step(TO + 10);
    margin_n = 1'b1; step(4);
    chk("R8 timeout ran under margin", {31'd0, sys_rst_n}, 32'd1);

    // R9: lockout priority and restart
    lockout = 1'b1; margin_n = 1'b0; step(6);
    chk("R9 lockout over margin", {23'd0, uv_out_n, ov_out_n, sys_rst_n}, 32'd0);
    margin_n = 1'b1; lockout = 1'b0; step(TO);
    chk("R9 lockout restarts timeout", {31'd0, sys_rst_n}, 32'd0);
    step(8);
    chk("R9 high after lockout", {31'd0, sys_rst_n}, 32'd1);

    // Random mixes (R1 R2 R7 R9)
    for (int k = 0; k < 60; k++) begin
      logic [N-1:0] u, o;
      logic mg, lk;
      u  = N'($urandom());
      o  = N'($urandom());
      mg = ($urandom() % 4) != 0;
      lk = ($urandom() % 8) == 0;
      uv_flag = u; ov_flag = o; margin_n = mg; lockout = lk;
      step(5);
      chk("R1 random uv", {28'd0, uv_out_n}, {28'd0, exp_chan(u, mg, lk)});
      chk("R1 random ov", {28'd0, ov_out_n}, {28'd0, exp_chan(o, mg, lk)});
      if (lk)
        chk("R9 random reset", {31'd0, sys_rst_n}, 32'd0);
      else if (!mg)
        chk("R7 random reset", {31'd0, sys_rst_n}, 32'd1);
      else if ((|u) || (|o))
        chk("R2 random reset", {31'd0, sys_rst_n}, 32'd0);
    end
    settle_clear();
    chk("R3 final release", {31'd0, sys_rst_n}, 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule